// File: doc/BRIEF.md
# Sequencer Control and Status Register

This block is the one register through which a host processor and an embedded microsequencer coordinate. It holds a sequencer hold-in-reset bit, an eight-bit status field that only the sequencer writes, and an eight-bit trigger field. The host may only set trigger bits and the sequencer may only clear them, so the two sides can exchange requests without a read-modify-write race.

The hold bit also steers memory access. While the sequencer is held, the host reaches program memory and is kept out of data memory. Releasing the sequencer swaps these two accesses. Starting an operation with a nonzero sequencer opcode raises trigger bit 0 on its own. The lowest status bit, inverted, is the sequencer's contribution to the engine's busy indication.

The power-up value of the hold bit is a parameter. Program storage in RAM starts held, because firmware must be loaded first. Storage in ROM starts released.

Top module: `seq_ctrl_reg`

## Requirements
- R1: After reset, bit 31 of the read word equals the PROG_IN_RAM parameter (1 for RAM, 0 for ROM), and the trigger field [7:0] and the status field [15:8] are zero.
- R2: A host write loads bit 31 from host data bit 31, and the new value appears on bit 31 and on seq_rst_o in the next cycle.
- R3: prog_sel_o equals bit 31 and data_sel_o is its complement at all times.
- R4: A host write sets every trigger bit whose data bit is 1. A data bit of 0 leaves that trigger bit unchanged.
- R5: A sequencer write clears every trigger bit whose data bit is 0. A data bit of 1 never sets a trigger bit.
- R6: op_start_i high with a nonzero op_code_i sets trigger bit 0. With op_code_i equal to 0, op_start_i has no effect on the register.
- R7: A sequencer write loads the status field [15:8] from sequencer data [15:8]. Host writes never change the status field.
- R8: run_busy_o is the complement of read bit 8 (status bit 0), so it is high until the sequencer raises that bit.
- R9: When a host or auto set and a sequencer clear hit the same trigger bit in one cycle, the bit ends set.
- R10: Bits [30:16] of the read word are always zero.
- R11: While bit 31 is 1, sequencer writes have no effect on either the trigger field or the status field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host write strobe |
| host_wdata_i | input | 32 | Host write data |
| seq_we_i | input | 1 | Sequencer write strobe |
| seq_wdata_i | input | 32 | Sequencer write data |
| op_start_i | input | 1 | Run bit being set in the function register |
| op_code_i | input | 3 | Sequencer operation field that accompanies the start |
| reg_rdata_o | output | 32 | Register read value, shared by host and sequencer |
| seq_rst_o | output | 1 | Holds the sequencer in reset |
| prog_sel_o | output | 1 | Host access to program memory enabled |
| data_sel_o | output | 1 | Host access to data memory enabled |
| run_busy_o | output | 1 | Sequencer contribution to the run/busy state |

## Verification
A host set of a trigger bit and a sequencer clear of that same bit can occur in the same cycle. An auto-set from an operation start can also coincide with a sequencer clear. The bench provokes both cases by driving the two write strobes, or the start and a sequencer write, in the same clock. It expects the contested bits to end set, and it expects the clear to take effect on every other bit. A sequencer write issued while the hold bit is 1 is checked by confirming that the whole read word is unchanged on the following cycle.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned TRIG_W   = 8;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned TRIG_LSB = 0;
  localparam int unsigned STAT_LSB = TRIG_LSB + TRIG_W;
  localparam int unsigned HOLD_BIT = REG_W - 1;
  localparam int unsigned OP_W     = 3;
  localparam int unsigned PAD_W    = HOLD_BIT - (STAT_LSB + STAT_W);
endpackage

// File: rtl/sc_trig_bank.sv
module sc_trig_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;  // set has priority
      else if (clr_i[i])  q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_stat_reg.sv
module sc_stat_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/sc_hold_ctl.sv
module sc_hold_ctl #(
  parameter bit PROG_IN_RAM = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic hold_o,
  output logic prog_sel_o,
  output logic data_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_o <= PROG_IN_RAM;
    else if (we_i) hold_o <= d_i;
  end

  assign prog_sel_o = hold_o;
  assign data_sel_o = ~hold_o;
endmodule

// File: rtl/seq_ctrl_reg.sv
module seq_ctrl_reg
  import seq_ctrl_pkg::*;
#(
  parameter bit PROG_IN_RAM = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [REG_W-1:0] host_wdata_i,
  input  logic             seq_we_i,
  input  logic [REG_W-1:0] seq_wdata_i,
  input  logic             op_start_i,
  input  logic [OP_W-1:0]  op_code_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             seq_rst_o,
  output logic             prog_sel_o,
  output logic             data_sel_o,
  output logic             run_busy_o
);
  logic              hold_q;
  logic              seq_wr_ok;
  logic              auto_set;
  logic [TRIG_W-1:0] trig_set, trig_clr, trig_q;
  logic [STAT_W-1:0] stat_q;

  // sequencer port is dead while held in reset
  assign seq_wr_ok = seq_we_i & ~hold_q;
  assign auto_set  = op_start_i & (op_code_i != '0);

  always_comb begin
    trig_set    = host_we_i ? host_wdata_i[TRIG_LSB +: TRIG_W] : '0;
    trig_set[0] = trig_set[0] | auto_set;
    trig_clr    = seq_wr_ok ? ~seq_wdata_i[TRIG_LSB +: TRIG_W] : '0;
  end

  sc_hold_ctl #(.PROG_IN_RAM(PROG_IN_RAM)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (host_we_i),
    .d_i        (host_wdata_i[HOLD_BIT]),
    .hold_o     (hold_q),
    .prog_sel_o (prog_sel_o),
    .data_sel_o (data_sel_o)
  );

  sc_trig_bank #(.W(TRIG_W)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trig_set),
    .clr_i  (trig_clr),
    .q_o    (trig_q)
  );

  sc_stat_reg #(.W(STAT_W)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (seq_wr_ok),
    .d_i    (seq_wdata_i[STAT_LSB +: STAT_W]),
    .q_o    (stat_q)
  );

  assign reg_rdata_o = {hold_q, {PAD_W{1'b0}}, stat_q, trig_q};
  assign seq_rst_o   = hold_q;
  assign run_busy_o  = ~stat_q[0];
endmodule

// File: rtl/seq_ctrl_chk.sv
module seq_ctrl_chk
  import seq_ctrl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_we_i,
  input logic [REG_W-1:0] host_wdata_i,
  input logic             seq_we_i,
  input logic             op_start_i,
  input logic [OP_W-1:0]  op_code_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             seq_rst_o,
  input logic             prog_sel_o,
  input logic             data_sel_o,
  input logic             run_busy_o
);
  // R2
  hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |=> (seq_rst_o == $past(host_wdata_i[HOLD_BIT])));
  // R3
  mem_steer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_sel_o == reg_rdata_o[HOLD_BIT]) && (data_sel_o != prog_sel_o));
  // R4
  host_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |=> ((reg_rdata_o[TRIG_W-1:0] & $past(host_wdata_i[TRIG_W-1:0]))
                   == $past(host_wdata_i[TRIG_W-1:0])));
  // R5
  no_seq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_we_i && !(op_start_i && op_code_i != '0)) |=>
      ((reg_rdata_o[TRIG_W-1:0] & ~$past(reg_rdata_o[TRIG_W-1:0])) == '0));
  // R7
  stat_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_we_i |=> $stable(reg_rdata_o[STAT_LSB +: STAT_W]));
  // R8
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_busy_o == !reg_rdata_o[STAT_LSB]);
  // R10
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[HOLD_BIT-1:STAT_LSB+STAT_W] == '0);
  // R11
  held_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_rst_o && !host_we_i && !op_start_i) |=> $stable(reg_rdata_o[STAT_LSB+STAT_W-1:0]));
endmodule

bind seq_ctrl_reg seq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_we_i    (host_we_i),
  .host_wdata_i (host_wdata_i),
  .seq_we_i     (seq_we_i),
  .op_start_i   (op_start_i),
  .op_code_i    (op_code_i),
  .reg_rdata_o  (reg_rdata_o),
  .seq_rst_o    (seq_rst_o),
  .prog_sel_o   (prog_sel_o),
  .data_sel_o   (data_sel_o),
  .run_busy_o   (run_busy_o)
);

// File: tb/sim_seq_ctrl_reg.sv
module sim_seq_ctrl_reg;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  typedef struct {
    logic [31:0] rdata;
    logic        hold;
    logic        busy;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_we_i = 1'b0;
  logic [31:0] host_wdata_i = '0;
  logic        seq_we_i = 1'b0;
  logic [31:0] seq_wdata_i = '0;
  logic        op_start_i = 1'b0;
  logic [2:0]  op_code_i = '0;
  logic [31:0] reg_rdata_o;
  logic        seq_rst_o, prog_sel_o, data_sel_o, run_busy_o;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // bench model state
  logic       m_hold;
  logic [7:0] m_trig, m_stat;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  seq_ctrl_reg u0 (.*);

  function automatic exp_t mk(string tag);
    exp_t e;
    e.rdata = {m_hold, 15'd0, m_stat, m_trig};
    e.hold  = m_hold;
    e.busy  = ~m_stat[0];
    e.tag   = tag;
    return e;
  endfunction

  task automatic step(input logic hwe, input logic [31:0] hw,
                      input logic swe, input logic [31:0] sw,
                      input logic st, input logic [2:0] op, input string tag);
    logic [7:0] set_v, clr_v;
    @(negedge clk_i); #1;
    host_we_i = hwe; host_wdata_i = hw;
    seq_we_i = swe;  seq_wdata_i = sw;
    op_start_i = st; op_code_i = op;
    set_v = (hwe ? hw[7:0] : 8'h00) | ((st && op != 3'd0) ? 8'h01 : 8'h00);
    clr_v = (swe && !m_hold) ? ~sw[7:0] : 8'h00;
    if (swe && !m_hold) m_stat = sw[15:8];
    m_trig = (m_trig & ~clr_v) | set_v;
    if (hwe) m_hold = hw[31];
    q.push_back(mk(tag));
  endtask

  // monitor: compares one expected item per falling edge
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (reg_rdata_o !== e.rdata) begin
        n_fail++;
        $display("FAIL %s rdata actual=%h expected=%h", e.tag, reg_rdata_o, e.rdata);
      end
      n_chk++;
      if ({seq_rst_o, prog_sel_o, data_sel_o, run_busy_o} !== {e.hold, e.hold, ~e.hold, e.busy}) begin
        n_fail++;
        $display("FAIL %s rst/prog/data/busy actual=%b expected=%b", e.tag,
                 {seq_rst_o, prog_sel_o, data_sel_o, run_busy_o},
                 {e.hold, e.hold, ~e.hold, e.busy});
      end
    end
  end

  initial begin
    m_hold = 1'b1; m_trig = '0; m_stat = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 R8 reset state
    step(0, 32'h0, 0, 32'h0, 0, 3'd0, "R1");
    // R11 sequencer write while held
    step(0, 32'h0, 1, 32'h0000_0100, 0, 3'd0, "R11");
    // R4 host sets triggers, stays held
    step(1, 32'h8000_00A5, 0, 32'h0, 0, 3'd0, "R4");
    // R2 R3 release; R7 R10 host writes to status/pad ignored; R4 zeros keep
    step(1, 32'h00FF_FF00, 0, 32'h0, 0, 3'd0, "R2_R3_R7_R10");
    // R5 clear with zeros, R7 status load, R8 busy drops
    step(0, 32'h0, 1, 32'h0000_01F0, 0, 3'd0, "R5_R7_R8");
    // R5 ones never set
    step(0, 32'h0, 1, 32'h0000_00FF, 0, 3'd0, "R5");
    // R6 start with op 0
    step(0, 32'h0, 0, 32'h0, 1, 3'd0, "R6");
    // R6 start with nonzero op
    step(0, 32'h0, 0, 32'h0, 1, 3'd3, "R6");
    // R9 host set vs sequencer clear
    step(1, 32'h0000_0002, 1, 32'h0000_0300, 0, 3'd0, "R9");
    // R9 auto set vs sequencer clear
    step(0, 32'h0, 1, 32'h0000_0100, 1, 3'd7, "R9");
    // R2 R3 hold again
    step(1, 32'h8000_0040, 0, 32'h0, 0, 3'd0, "R2_R3");
    // R11 clear attempt while held
    step(0, 32'h0, 1, 32'h0000_0000, 0, 3'd0, "R11");
    step(0, 32'h0, 0, 32'h0, 0, 3'd0, "idle");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule